// File: doc/BRIEF.md
# Configurable Macrocell Storage Element

This block is the state-holding part of a programmable logic cell. A static configuration word chooses what it stores and when. The stored bit can behave as a D, T, JK or SR flip-flop, or as a level-sensitive latch. Its data comes from one of three places: the cell's XOR result, a dedicated product term, or the pin input. It can be clocked by any of three global clocks or by a product-term clock. With a global clock, a product-term enable can gate it.

Asynchronous clear and set are each taken from a selectable source. The clear can also be the OR of the global clear and a product term. Two independent selectors decide whether the cell output and the buried feedback show the stored bit or the combinational XOR result. Surrounding logic drives the configuration once and then treats the block as a small, fixed-function storage cell.

Top module: `mcell_storage`

## Requirements
- R1: In D mode, `cfg_dsrc` chooses the value stored at a clock edge: 0 selects `xor_in`, 1 selects `pt_data`, 2 selects `pin_in`, and 3 behaves like 0.
- R2: `cfg_csel` values 0 to 2 pick `gclk[0]` to `gclk[2]`, and value 3 picks `pt_clk`. The stored bit changes only on a rising edge of the picked clock. Edges on the other clocks have no effect.
- R3: With `cfg_mode` = 1 (T mode), each active edge inverts the stored bit when `xor_in` is 1 and leaves it unchanged when `xor_in` is 0.
- R4: With `cfg_mode` = 2 (JK mode), J is `xor_in` and K is `pt_data`. At an active edge, 00 holds, 10 sets, 01 clears and 11 inverts the stored bit.
- R5: With `cfg_mode` = 3 (SR mode), S is `xor_in` and R is `pt_data`. At an active edge, 10 sets, 01 clears, and 00 or 11 hold the stored bit.
- R6: With `cfg_mode` = 4 (latch mode), the stored bit follows the selected data source while the picked clock is high. It keeps its value while the clock is low. `cfg_mode` = 0 is D mode, and the values 5 to 7 act as D mode.
- R7: When `cfg_cen_on` = 1 and a global clock is picked, edges that arrive while `pt_cen` is 0 are ignored. When `pt_clk` is picked, `pt_cen` has no effect.
- R8: `cfg_ar_src` picks the asynchronous clear: 0 none, 1 `gclr`, 2 `pt_rst`, 3 either one. An active clear forces the stored bit to 0 at once, without a clock edge. A source that is not picked has no effect.
- R9: With `cfg_ap_on` = 1, a high `pt_pre` forces the stored bit to 1 at once. When clear and set are active together, the clear wins and the bit is 0.
- R10: `cell_out` shows the stored bit when `cfg_out_reg` = 1, and shows `xor_in` when `cfg_out_reg` = 0.
- R11: `fb_out` shows the stored bit when `cfg_fb_reg` = 1, and shows `xor_in` when `cfg_fb_reg` = 0. This choice is independent of `cfg_out_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_mode | input | 3 | Storage behaviour: 0 D, 1 T, 2 JK, 3 SR, 4 latch |
| cfg_dsrc | input | 2 | Data source: 0 XOR result, 1 product term, 2 pin, 3 XOR result |
| cfg_csel | input | 2 | Clock pick: 0..2 global clock index, 3 product-term clock |
| cfg_cen_on | input | 1 | Allows `pt_cen` to gate global-clock edges |
| cfg_ar_src | input | 2 | Clear source: 0 none, 1 global clear, 2 product term, 3 both ORed |
| cfg_ap_on | input | 1 | Allows `pt_pre` to set the stored bit |
| cfg_out_reg | input | 1 | 1: `cell_out` shows the stored bit; 0: it shows `xor_in` |
| cfg_fb_reg | input | 1 | 1: `fb_out` shows the stored bit; 0: it shows `xor_in` |
| xor_in | input | 1 | XOR result of the cell; also T, J and S input |
| pt_data | input | 1 | Dedicated data product term; also K and R input |
| pin_in | input | 1 | Direct pin input |
| gclk | input | 3 | Global clocks |
| pt_clk | input | 1 | Product-term clock |
| pt_cen | input | 1 | Product-term clock enable |
| gclr | input | 1 | Global clear |
| pt_rst | input | 1 | Product-term clear |
| pt_pre | input | 1 | Product-term set |
| cell_out | output | 1 | Cell output |
| fb_out | output | 1 | Buried feedback |

## Verification
The assertions check five behaviours on every `gclk[0]` edge:
- the cell output is 0 whenever a picked clear source is active;
- the feedback matches the cell output whenever both selectors agree;
- a bit clocked by `gclk[0]` in D mode captures the selected source one edge later;
- the same bit in T mode inverts according to `xor_in`;
- a disabled edge leaves the bit unchanged.

Several behaviours need the bench's directed scenarios. These are the latch's transparent and holding phases, the other clock sources and the product-term clock's indifference to the enable. They also include the JK and SR truth tables, the clear-over-set priority, and the rejection of clear sources that are not picked.

// File: rtl/mc_pkg.sv
package mc_pkg;

    localparam int MC_NUM_GCLK = 3;
    localparam int MC_CSEL_W   = $clog2(MC_NUM_GCLK + 1);
    localparam int MC_NSRC     = 1 << MC_CSEL_W;

    typedef enum logic [2:0] {
        MC_D     = 3'd0,
        MC_T     = 3'd1,
        MC_JK    = 3'd2,
        MC_SR    = 3'd3,
        MC_LATCH = 3'd4
    } mc_mode_e;

    typedef enum logic [1:0] {
        DS_XOR  = 2'd0,
        DS_PT   = 2'd1,
        DS_PIN  = 2'd2,
        DS_XOR2 = 2'd3
    } mc_dsrc_e;

    typedef struct packed {
        mc_mode_e               mode;
        mc_dsrc_e               dsrc;
        logic [MC_CSEL_W-1:0]   csel;
        logic                   cen_on;
        logic [1:0]             ar_src;
        logic                   ap_on;
        logic                   out_reg;
        logic                   fb_reg;
    } mc_cfg_t;

    // Next value of an edge-triggered bit; a and b are the two control inputs.
    function automatic logic mc_next(mc_mode_e m, logic q, logic d, logic a, logic b);
        logic r;
        case (m)
            MC_T:  r = q ^ a;
            MC_JK: begin
                if (a && b)      r = ~q;
                else if (a)      r = 1'b1;
                else if (b)      r = 1'b0;
                else             r = q;
            end
            MC_SR: begin
                if (a && !b)     r = 1'b1;
                else if (b && !a) r = 1'b0;
                else             r = q;
            end
            default: r = d;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mc_src_sel.sv
module mc_src_sel
    import mc_pkg::*;
(
    input  mc_cfg_t                cfg,
    input  logic                   xor_in,
    input  logic                   pt_data,
    input  logic                   pin_in,
    input  logic [MC_NUM_GCLK-1:0] gclk,
    input  logic                   pt_clk,
    input  logic                   pt_cen,
    input  logic                   gclr,
    input  logic                   pt_rst,
    input  logic                   pt_pre,
    output logic                   d_sel,
    output logic                   clk_sel,
    output logic                   cen_ok,
    output logic                   ar_act,
    output logic                   ap_act
);

    logic [MC_NSRC-1:0] clk_src;
    logic               global_pick;

    // Clock candidates: the global clocks first, the product-term clock fills the rest.
    for (genvar i = 0; i < MC_NSRC; i++) begin : g_clk_src
        if (i < MC_NUM_GCLK) begin : g_glob
            assign clk_src[i] = gclk[i];
        end else begin : g_pterm
            assign clk_src[i] = pt_clk;
        end
    end

    assign clk_sel     = clk_src[cfg.csel];
    assign global_pick = (cfg.csel < MC_CSEL_W'(MC_NUM_GCLK));
    assign cen_ok      = !(cfg.cen_on && global_pick) || pt_cen;

    always_comb begin
        case (cfg.dsrc)
            DS_PT:   d_sel = pt_data;
            DS_PIN:  d_sel = pin_in;
            default: d_sel = xor_in;
        endcase
    end

    assign ar_act = (cfg.ar_src[0] && gclr) || (cfg.ar_src[1] && pt_rst);
    assign ap_act = cfg.ap_on && pt_pre;

endmodule

// File: rtl/mc_store.sv
module mc_store
    import mc_pkg::*;
(
    input  logic     clk_sel,
    input  logic     cen_ok,
    input  logic     ar_act,
    input  logic     ap_act,
    input  mc_mode_e mode,
    input  logic     d_sel,
    input  logic     a_in,
    input  logic     b_in,
    output logic     q
);

    logic q_ff;
    logic q_lat;
    logic nxt;
    logic is_lat;

    assign is_lat = (mode == MC_LATCH);
    assign nxt    = mc_next(mode, q_ff, d_sel, a_in, b_in);

    // Edge-triggered path: clear dominates set.
    always_ff @(posedge clk_sel or posedge ar_act or posedge ap_act) begin
        if (ar_act)
            q_ff <= 1'b0;
        else if (ap_act)
            q_ff <= 1'b1;
        else if (cen_ok && !is_lat)
            q_ff <= nxt;
    end

    // Level-sensitive path, transparent only in latch mode.
    always_latch begin
        if (ar_act)
            q_lat = 1'b0;
        else if (ap_act)
            q_lat = 1'b1;
        else if (is_lat && clk_sel && cen_ok)
            q_lat = d_sel;
    end

    assign q = is_lat ? q_lat : q_ff;

endmodule

// File: rtl/mcell_storage.sv
module mcell_storage
    import mc_pkg::*;
(
    input  logic [2:0]             cfg_mode,
    input  logic [1:0]             cfg_dsrc,
    input  logic [MC_CSEL_W-1:0]   cfg_csel,
    input  logic                   cfg_cen_on,
    input  logic [1:0]             cfg_ar_src,
    input  logic                   cfg_ap_on,
    input  logic                   cfg_out_reg,
    input  logic                   cfg_fb_reg,
    input  logic                   xor_in,
    input  logic                   pt_data,
    input  logic                   pin_in,
    input  logic [MC_NUM_GCLK-1:0] gclk,
    input  logic                   pt_clk,
    input  logic                   pt_cen,
    input  logic                   gclr,
    input  logic                   pt_rst,
    input  logic                   pt_pre,
    output logic                   cell_out,
    output logic                   fb_out
);

    mc_cfg_t cfg;
    logic    d_sel;
    logic    clk_sel;
    logic    cen_ok;
    logic    ar_act;
    logic    ap_act;
    logic    q;

    always_comb begin
        cfg.mode    = mc_mode_e'(cfg_mode);
        cfg.dsrc    = mc_dsrc_e'(cfg_dsrc);
        cfg.csel    = cfg_csel;
        cfg.cen_on  = cfg_cen_on;
        cfg.ar_src  = cfg_ar_src;
        cfg.ap_on   = cfg_ap_on;
        cfg.out_reg = cfg_out_reg;
        cfg.fb_reg  = cfg_fb_reg;
    end

    mc_src_sel u_sel (
        .cfg     (cfg),
        .xor_in  (xor_in),
        .pt_data (pt_data),
        .pin_in  (pin_in),
        .gclk    (gclk),
        .pt_clk  (pt_clk),
        .pt_cen  (pt_cen),
        .gclr    (gclr),
        .pt_rst  (pt_rst),
        .pt_pre  (pt_pre),
        .d_sel   (d_sel),
        .clk_sel (clk_sel),
        .cen_ok  (cen_ok),
        .ar_act  (ar_act),
        .ap_act  (ap_act)
    );

    mc_store u_store (
        .clk_sel (clk_sel),
        .cen_ok  (cen_ok),
        .ar_act  (ar_act),
        .ap_act  (ap_act),
        .mode    (cfg.mode),
        .d_sel   (d_sel),
        .a_in    (xor_in),
        .b_in    (pt_data),
        .q       (q)
    );

    assign cell_out = cfg.out_reg ? q : xor_in;
    assign fb_out   = cfg.fb_reg  ? q : xor_in;

endmodule

// File: rtl/mcell_storage_chk.sv
module mcell_storage_chk
    import mc_pkg::*;
(
    input logic [2:0]             cfg_mode,
    input logic [1:0]             cfg_dsrc,
    input logic [MC_CSEL_W-1:0]   cfg_csel,
    input logic                   cfg_cen_on,
    input logic [1:0]             cfg_ar_src,
    input logic                   cfg_ap_on,
    input logic                   cfg_out_reg,
    input logic                   cfg_fb_reg,
    input logic                   xor_in,
    input logic                   pt_data,
    input logic                   pin_in,
    input logic [MC_NUM_GCLK-1:0] gclk,
    input logic                   pt_clk,
    input logic                   pt_cen,
    input logic                   gclr,
    input logic                   pt_rst,
    input logic                   pt_pre,
    input logic                   cell_out,
    input logic                   fb_out
);

    logic       armed = 1'b0;
    logic       ar_lvl;
    logic       ap_lvl;
    logic       d_exp;
    logic [13:0] cfg_all;
    logic       plain0;

    assign ar_lvl  = (cfg_ar_src[0] & gclr) | (cfg_ar_src[1] & pt_rst);
    assign ap_lvl  = cfg_ap_on & pt_pre;
    assign d_exp   = (cfg_dsrc == 2'd1) ? pt_data : (cfg_dsrc == 2'd2) ? pin_in : xor_in;
    assign cfg_all = {cfg_mode, cfg_dsrc, cfg_csel, cfg_cen_on, cfg_ar_src,
                      cfg_ap_on, cfg_out_reg, cfg_fb_reg};
    assign plain0  = (cfg_csel == '0) && cfg_out_reg && !ar_lvl && !ap_lvl;

    always_ff @(posedge gclk[0]) begin
        if (gclr && cfg_ar_src[0])
            armed <= 1'b1;
    end

    assert_clear_forces_zero_R8: assert property (@(posedge gclk[0]) disable iff (!armed)
        (ar_lvl && cfg_out_reg) |-> (cell_out == 1'b0));

    assert_fb_tracks_out_R11: assert property (@(posedge gclk[0]) disable iff (!armed)
        (cfg_fb_reg == cfg_out_reg) |-> (fb_out == cell_out));

    assert_d_capture_R1: assert property (@(posedge gclk[0]) disable iff (!armed)
        (plain0 && cfg_mode == 3'd0 && !cfg_cen_on)
        |=> (!$stable(cfg_all) || ar_lvl || ap_lvl || cell_out == $past(d_exp)));

    assert_toggle_R3: assert property (@(posedge gclk[0]) disable iff (!armed)
        (plain0 && cfg_mode == 3'd1 && !cfg_cen_on)
        |=> (!$stable(cfg_all) || ar_lvl || ap_lvl || cell_out == $past(cell_out ^ xor_in)));

    assert_disabled_edge_holds_R7: assert property (@(posedge gclk[0]) disable iff (!armed)
        (plain0 && cfg_mode != 3'd4 && cfg_cen_on && !pt_cen)
        |=> (!$stable(cfg_all) || ar_lvl || ap_lvl || $stable(cell_out)));

endmodule

bind mcell_storage mcell_storage_chk u_chk (.*);

// File: tb/mcell_storage_tb.sv
`timescale 1ns/100ps
module mcell_storage_tb;

    typedef struct {
        int   req;
        logic co;
        logic fb;
    } exp_t;

    logic [2:0] cfg_mode;
    logic [1:0] cfg_dsrc;
    logic [1:0] cfg_csel;
    logic       cfg_cen_on;
    logic [1:0] cfg_ar_src;
    logic       cfg_ap_on;
    logic       cfg_out_reg;
    logic       cfg_fb_reg;
    logic       xor_in, pt_data, pin_in;
    logic       clk0 = 1'b0;
    logic       gclk1, gclk2;
    logic       pt_clk, pt_cen, gclr, pt_rst, pt_pre;
    logic       cell_out, fb_out;

    int   n_vec  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;
    exp_t sb[$];

    always #2 clk0 = ~clk0;

    mcell_storage u_dut (
        .cfg_mode    (cfg_mode),
        .cfg_dsrc    (cfg_dsrc),
        .cfg_csel    (cfg_csel),
        .cfg_cen_on  (cfg_cen_on),
        .cfg_ar_src  (cfg_ar_src),
        .cfg_ap_on   (cfg_ap_on),
        .cfg_out_reg (cfg_out_reg),
        .cfg_fb_reg  (cfg_fb_reg),
        .xor_in      (xor_in),
        .pt_data     (pt_data),
        .pin_in      (pin_in),
        .gclk        ({gclk2, gclk1, clk0}),
        .pt_clk      (pt_clk),
        .pt_cen      (pt_cen),
        .gclr        (gclr),
        .pt_rst      (pt_rst),
        .pt_pre      (pt_pre),
        .cell_out    (cell_out),
        .fb_out      (fb_out)
    );

    // Driver side: move to just after a falling edge of the free-running clock.
    task automatic step();
        @(negedge clk0);
        #0.5;
    endtask

    task automatic put(int r, logic c, logic f);
        exp_t e;
        e.req = r;
        e.co  = c;
        e.fb  = f;
        sb.push_back(e);
    endtask

    // Monitor: compares queued expectations at the next falling edge.
    initial begin
        forever begin
            @(negedge clk0);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (cell_out !== e.co || fb_out !== e.fb) begin
                    n_fail++;
                    $display("FAIL R%0d: cell_out=%b fb_out=%b expected cell_out=%b fb_out=%b",
                             e.req, cell_out, fb_out, e.co, e.fb);
                end
            end
        end
    end

    initial begin
        #80000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        cfg_mode = 3'd0; cfg_dsrc = 2'd0; cfg_csel = 2'd0; cfg_cen_on = 1'b0;
        cfg_ar_src = 2'd1; cfg_ap_on = 1'b0; cfg_out_reg = 1'b1; cfg_fb_reg = 1'b1;
        xor_in = 0; pt_data = 0; pin_in = 0; gclk1 = 0; gclk2 = 0;
        pt_clk = 0; pt_cen = 0; gclr = 0; pt_rst = 0; pt_pre = 0;

        // R8: global clear gives the reset state
        step(); gclr = 1;                         put(8, 0, 0);
        // R1: data source selection in D mode
        step(); gclr = 0; xor_in = 1;             put(1, 1, 1);
        step(); cfg_dsrc = 2'd1; pt_data = 0;     put(1, 0, 0);
        step(); pt_data = 1;                      put(1, 1, 1);
        step(); cfg_dsrc = 2'd2; pin_in = 0;      put(1, 0, 0);
        step(); pin_in = 1; pt_data = 0; xor_in = 0; put(1, 1, 1);
        step(); cfg_dsrc = 2'd3; xor_in = 0;      put(1, 0, 0);
        step(); xor_in = 1;                       put(1, 1, 1);
        step(); cfg_dsrc = 2'd2;                  put(1, 1, 1);
        // R10: output select
        step(); cfg_out_reg = 0; xor_in = 0;      put(10, 0, 1);
        step(); xor_in = 1;                       put(10, 1, 1);
        // R11: feedback select independent of output select
        step(); cfg_out_reg = 1; cfg_fb_reg = 0; xor_in = 0; put(11, 1, 0);
        step(); xor_in = 1;                       put(11, 1, 1);
        step(); cfg_fb_reg = 1; xor_in = 0;       put(11, 1, 1);
        // R2: clock source selection
        step(); cfg_csel = 2'd1; pin_in = 0;      put(2, 1, 1);
        step();                                   put(2, 1, 1);
        step(); gclk1 = 1;                        put(2, 0, 0);
        step(); gclk1 = 0; pin_in = 1;            put(2, 0, 0);
        step(); cfg_csel = 2'd2; gclk1 = 1;       put(2, 0, 0);
        step(); gclk1 = 0; gclk2 = 1;             put(2, 1, 1);
        step(); gclk2 = 0; cfg_csel = 2'd3; pin_in = 0; put(2, 1, 1);
        step(); pt_clk = 1;                       put(2, 0, 0);
        step(); pt_clk = 0;                       put(2, 0, 0);
        // R7: clock enable on a global clock, ignored on the product-term clock
        step(); cfg_csel = 2'd0; cfg_cen_on = 1; pt_cen = 0; pin_in = 1; put(7, 0, 0);
        step();                                   put(7, 0, 0);
        step(); pt_cen = 1;                       put(7, 1, 1);
        step(); pt_cen = 0; pin_in = 0;           put(7, 1, 1);
        step(); cfg_csel = 2'd3;                  put(7, 1, 1);
        step(); pt_clk = 1;                       put(7, 0, 0);
        step(); pt_clk = 0; cfg_csel = 2'd0; cfg_cen_on = 0; put(7, 0, 0);
        // R3: T mode
        step(); cfg_mode = 3'd1; xor_in = 1;      put(3, 1, 1);
        step();                                   put(3, 0, 0);
        step(); xor_in = 0;                       put(3, 0, 0);
        step(); xor_in = 1;                       put(3, 1, 1);
        step(); xor_in = 0;                       put(3, 1, 1);
        // R4: JK mode (J = xor_in, K = pt_data)
        step(); cfg_mode = 3'd2; xor_in = 0; pt_data = 1; put(4, 0, 0);
        step(); xor_in = 1; pt_data = 0;          put(4, 1, 1);
        step(); xor_in = 0; pt_data = 0;          put(4, 1, 1);
        step(); xor_in = 1; pt_data = 1;          put(4, 0, 0);
        step();                                   put(4, 1, 1);
        // R5: SR mode (S = xor_in, R = pt_data)
        step(); cfg_mode = 3'd3; xor_in = 0; pt_data = 1; put(5, 0, 0);
        step(); xor_in = 1; pt_data = 0;          put(5, 1, 1);
        step(); xor_in = 1; pt_data = 1;          put(5, 1, 1);
        step(); xor_in = 0; pt_data = 1;          put(5, 0, 0);
        step(); xor_in = 1; pt_data = 1;          put(5, 0, 0);
        // R6: latch mode on gclk[1]
        step(); cfg_mode = 3'd4; cfg_csel = 2'd1; xor_in = 0; pt_data = 0; pin_in = 1; put(6, 0, 0);
        step(); gclk1 = 1;                        put(6, 1, 1);
        step(); pin_in = 0;                       put(6, 0, 0);
        step(); pin_in = 1;                       put(6, 1, 1);
        step(); gclk1 = 0;                        put(6, 1, 1);
        step(); pin_in = 0;                       put(6, 1, 1);
        // R8 / R9: asynchronous clear and set sources
        step(); cfg_mode = 3'd0; cfg_ar_src = 2'd2; cfg_ap_on = 1; pt_pre = 1; put(9, 1, 1);
        step(); pt_pre = 0;                       put(9, 1, 1);
        step(); pt_rst = 1;                       put(8, 0, 0);
        step(); pt_pre = 1;                       put(9, 0, 0);
        step(); pt_pre = 0; pt_rst = 0;           put(9, 0, 0);
        step(); pt_pre = 1;                       put(9, 1, 1);
        step(); pt_pre = 0; gclr = 1;             put(8, 1, 1);
        step(); cfg_ar_src = 2'd0;                put(8, 1, 1);
        step(); gclr = 0; cfg_ar_src = 2'd3; pt_rst = 1; put(8, 0, 0);
        step(); pt_rst = 0; pt_pre = 1;           put(9, 1, 1);
        step(); pt_pre = 0; gclr = 1;             put(8, 0, 0);
        step(); gclr = 0;                         put(8, 0, 0);

        step();
        step();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule